// File: doc/BRIEF.md
# Pipelined Pixel Readout Timing Controller

This block generates the control strobes that step a multi-channel video chain through a frame of pixels. Each pixel passes through four stages in order: the analog output settles, an integrate-and-hold circuit integrates the settled signal, the ADC converts the held value, and then the results of all channels are sent to the host link one channel at a time. To shorten the frame, the settle and integrate stages of the next pixel run while the ADC converts the previous one. During the data burst, no analog strobe toggles, so the chain stays quiet.

A host writes the pixel count, the four stage lengths in clock ticks and a fast-mode select, then pulses start. The block samples all of these only at that start pulse. It then works through the frame by itself and pulses done once the last channel of the last pixel has left. Fast mode uses a second, shorter per-channel dwell during the burst. This trades higher noise for a shorter pixel period.

Top module: `pix_readout_seq`

## Requirements
- R1: After reset, and whenever reset is asserted mid-frame, integ_o, hold_o, conv_start_o, burst_o and done_o are all low, and the block waits for start_i.
- R2: The first pixel of a frame has no conversion to overlap. Its window is settle_len_i idle ticks, then integ_o high for integ_len_i cycles, then hold_o high for one cycle directly after integ_o falls. No conv_start_o occurs in that window.
- R3: Each later analog window begins with a one-cycle conv_start_o for the pixel held last. In the same window the next pixel settles, integrates and is held. The window lasts the larger of settle+integ+1 and conv_len_i ticks, and conv_start_o never coincides with integ_o or hold_o.
- R4: Every conversion window is followed by a burst of N_CH one-cycle burst_o strobes. burst_ch_o counts 0, 1, … N_CH−1 on successive strobes, and the strobes are spaced by the dwell: dwell_len_i when fast_i was 0 at start, dwell_fast_len_i when it was 1.
- R5: While a burst is running, integ_o, hold_o and conv_start_o stay low.
- R6: After the last pixel is held, one final window of exactly conv_len_i ticks carries only its conversion, with no settle, integrate or hold, followed by its burst.
- R7: If start_i is sampled high at clock edge e0 and the frame has P pixels, done_o is high for exactly one cycle, namely cycle A + (P−1)(M + B) + C + B + 1 after e0. Here A = settle+integ+1, C = conv, M = max(A, C) and B = N_CH × dwell.
- R8: A frame of P pixels yields exactly P integrate windows of integ_len_i cycles each, P hold pulses, P conversion starts and P × N_CH burst strobes.
- R9: All inputs except reset are sampled only at a start_i accepted while idle. start_i pulses and input changes during a frame alter neither its timing nor its counts, and while idle no strobe is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame (accepted only while idle) |
| pix_count_i | input | PW | Pixels in the frame, 1 or more |
| fast_i | input | 1 | Select the short burst dwell |
| settle_len_i | input | TW | Settle ticks, 1 or more |
| integ_len_i | input | TW | Integrate ticks (sets gain), 1 or more |
| conv_len_i | input | TW | Conversion ticks, 1 or more |
| dwell_len_i | input | TW | Per-channel burst dwell, normal mode, 1 or more |
| dwell_fast_len_i | input | TW | Per-channel burst dwell, fast mode, 1 or more |
| integ_o | output | 1 | Integrate window active |
| hold_o | output | 1 | One-cycle hold capture strobe |
| conv_start_o | output | 1 | One-cycle ADC conversion start |
| burst_o | output | 1 | One-cycle strobe at the start of each channel's dwell |
| burst_ch_o | output | $clog2(N_CH) | Channel index belonging to burst_o |
| done_o | output | 1 | One-cycle frame completion |

## Verification
The assertions assume that the pixel count and every stage length are at least one when start is accepted. This keeps integration after conversion start and the hold one cycle after integration, so the exclusion and ordering properties hold. Every stimulus vector keeps to those limits. The vectors cover the cases where the analog part dominates the window, where the conversion dominates it, and where both are equal, plus a one-pixel frame. The disturbance run raises start and writes out-of-range-free but different lengths only while a frame is in flight. The mid-frame reset is applied asynchronously, at a point where no check is waiting on a later edge.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIN   = 2'd1,
    ST_BURST = 2'd2
  } rdo_state_e;
endpackage

// File: rtl/rdo_window.sv
// One analog window: optional conversion of the held pixel, optional settle/integrate/hold of the next.
module rdo_window #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          an_act_i,
  input  logic          cv_act_i,
  input  logic [TW-1:0] settle_i,
  input  logic [TW-1:0] integ_i,
  input  logic [TW-1:0] conv_i,
  output logic          integ_o,
  output logic          hold_o,
  output logic          conv_start_o,
  output logic          last_o
);
  localparam int CW = TW + 1;

  logic [CW-1:0] cnt, a_len, c_len, len, integ_end;

  always_comb begin
    integ_end = CW'(settle_i) + CW'(integ_i);
    a_len     = an_act_i ? integ_end + CW'(1) : '0;
    c_len     = cv_act_i ? CW'(conv_i) : '0;
    len       = (a_len > c_len) ? a_len : c_len;
  end

  assign last_o       = run_i && (cnt == len - CW'(1));
  assign integ_o      = run_i && an_act_i && (cnt >= CW'(settle_i)) && (cnt < integ_end);
  assign hold_o       = run_i && an_act_i && (cnt == integ_end);
  assign conv_start_o = run_i && cv_act_i && (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt <= '0;
    else if (!run_i || last_o) cnt <= '0;
    else                     cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/rdo_burst.sv
// Serial channel burst: one strobe per channel, each held for the dwell.
module rdo_burst #(
  parameter int N_CH = 32,
  parameter int TW   = 8,
  localparam int CHW = $clog2(N_CH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [TW-1:0]  dwell_i,
  output logic           stb_o,
  output logic [CHW-1:0] ch_o,
  output logic           last_o
);
  logic [TW-1:0] dcnt;
  logic          dwell_end;

  assign dwell_end = (dcnt == dwell_i - TW'(1));
  assign stb_o     = run_i && (dcnt == '0);
  assign last_o    = run_i && dwell_end && (ch_o == CHW'(N_CH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt <= '0;
      ch_o <= '0;
    end else if (!run_i) begin
      dcnt <= '0;
      ch_o <= '0;
    end else if (dwell_end) begin
      dcnt <= '0;
      ch_o <= (ch_o == CHW'(N_CH - 1)) ? '0 : ch_o + CHW'(1);
    end else begin
      dcnt <= dcnt + TW'(1);
    end
  end
endmodule

// File: rtl/pix_readout_seq.sv
module pix_readout_seq
  import rdo_pkg::*;
#(
  parameter int N_CH = 32,
  parameter int TW   = 8,
  parameter int PW   = 8,
  localparam int CHW = $clog2(N_CH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [PW-1:0]  pix_count_i,
  input  logic           fast_i,
  input  logic [TW-1:0]  settle_len_i,
  input  logic [TW-1:0]  integ_len_i,
  input  logic [TW-1:0]  conv_len_i,
  input  logic [TW-1:0]  dwell_len_i,
  input  logic [TW-1:0]  dwell_fast_len_i,
  output logic           integ_o,
  output logic           hold_o,
  output logic           conv_start_o,
  output logic           burst_o,
  output logic [CHW-1:0] burst_ch_o,
  output logic           done_o
);
  rdo_state_e    state;
  logic [PW-1:0] cfg_pix;
  logic [TW-1:0] cfg_settle, cfg_integ, cfg_conv, cfg_dwell;
  logic          an_act, cv_act, pend;
  logic [PW:0]   n_set, n_nxt;
  logic          win_last, burst_last;
  logic          busy, in_burst;

  assign busy     = (state != ST_IDLE);
  assign in_burst = (state == ST_BURST);
  assign n_nxt    = n_set + (PW+1)'(an_act);

  rdo_window #(.TW(TW)) i_window (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (state == ST_WIN),
    .an_act_i     (an_act),
    .cv_act_i     (cv_act),
    .settle_i     (cfg_settle),
    .integ_i      (cfg_integ),
    .conv_i       (cfg_conv),
    .integ_o      (integ_o),
    .hold_o       (hold_o),
    .conv_start_o (conv_start_o),
    .last_o       (win_last)
  );

  rdo_burst #(.N_CH(N_CH), .TW(TW)) i_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (in_burst),
    .dwell_i (cfg_dwell),
    .stb_o   (burst_o),
    .ch_o    (burst_ch_o),
    .last_o  (burst_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      cfg_pix    <= '0;
      cfg_settle <= '0;
      cfg_integ  <= '0;
      cfg_conv   <= '0;
      cfg_dwell  <= '0;
      an_act     <= 1'b0;
      cv_act     <= 1'b0;
      pend       <= 1'b0;
      n_set      <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          cfg_pix    <= pix_count_i;
          cfg_settle <= settle_len_i;
          cfg_integ  <= integ_len_i;
          cfg_conv   <= conv_len_i;
          cfg_dwell  <= fast_i ? dwell_fast_len_i : dwell_len_i;
          an_act     <= 1'b1;
          cv_act     <= 1'b0;
          pend       <= 1'b0;
          n_set      <= '0;
          state      <= ST_WIN;
        end
        ST_WIN: if (win_last) begin
          n_set <= n_nxt;
          if (cv_act) begin
            pend  <= an_act;
            state <= ST_BURST;
          end else begin
            // first window: nothing converted yet, go straight to the next window
            cv_act <= 1'b1;
            an_act <= (n_nxt < {1'b0, cfg_pix});
          end
        end
        ST_BURST: if (burst_last) begin
          if (pend) begin
            cv_act <= 1'b1;
            an_act <= (n_set < {1'b0, cfg_pix});
            state  <= ST_WIN;
          end else begin
            cv_act <= 1'b0;
            an_act <= 1'b0;
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pix_readout_seq_chk.sv
module pix_readout_seq_chk #(
  parameter int N_CH = 32,
  localparam int CHW = $clog2(N_CH)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           busy,
  input logic           in_burst,
  input logic           integ_o,
  input logic           hold_o,
  input logic           conv_start_o,
  input logic           burst_o,
  input logic [CHW-1:0] burst_ch_o,
  input logic           done_o
);
  logic [CHW-1:0] prev_ch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_ch <= '0;
    else if (burst_o) prev_ch <= burst_ch_o;
  end

  assert_hold_after_integ_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> $past(integ_o) && !integ_o);

  assert_conv_alone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> !integ_o && !hold_o);

  assert_ch_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_o && burst_ch_o != '0) |-> burst_ch_o == prev_ch + CHW'(1));

  assert_quiet_burst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_burst |-> !integ_o && !hold_o && !conv_start_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_burst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(in_burst) && !busy);

  assert_idle_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !integ_o && !hold_o && !conv_start_o && !burst_o);
endmodule

bind pix_readout_seq pix_readout_seq_chk #(.N_CH(N_CH)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy         (busy),
  .in_burst     (in_burst),
  .integ_o      (integ_o),
  .hold_o       (hold_o),
  .conv_start_o (conv_start_o),
  .burst_o      (burst_o),
  .burst_ch_o   (burst_ch_o),
  .done_o       (done_o)
);

// File: tb/test_pix_readout_seq.sv
`timescale 1ns/1ps
module test_pix_readout_seq;
  localparam int N_CH = 32;
  localparam int TW   = 8;
  localparam int PW   = 8;
  localparam int CHW  = $clog2(N_CH);

  // P, settle, integ, conv, dwell, dwell_fast, fast
  localparam int NV = 6;
  localparam int VEC [NV][7] = '{
    '{1, 3, 2, 4, 2, 1, 0},
    '{3, 3, 2, 4, 2, 1, 0},
    '{3, 2, 1, 9, 1, 1, 0},
    '{2, 5, 3, 2, 3, 1, 1},
    '{4, 1, 1, 3, 1, 1, 0},
    '{5, 4, 4, 6, 4, 2, 1}
  };

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [PW-1:0]  pix_count_i = '0;
  logic           fast_i = 1'b0;
  logic [TW-1:0]  settle_len_i = '0, integ_len_i = '0, conv_len_i = '0;
  logic [TW-1:0]  dwell_len_i = '0, dwell_fast_len_i = '0;
  logic           integ_o, hold_o, conv_start_o, burst_o, done_o;
  logic [CHW-1:0] burst_ch_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  pix_readout_seq #(.N_CH(N_CH), .TW(TW), .PW(PW)) i_pix_readout_seq (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_frame(int p, int s, int i, int c, int d, int df, int f, bit disturb, string tag);
    int a, m, de, b, t;
    int k, done_k, n_int_cyc, n_int_win, n_hold, n_conv, n_stb;
    int stb1_k, stb2_k, burst_left, quiet_bad, ch_bad, first_win_conv;
    bit prev_int;
    a  = s + i + 1;
    m  = (a > c) ? a : c;
    de = f ? df : d;
    b  = N_CH * de;
    t  = a + (p - 1) * (m + b) + c + b;
    k = 0; done_k = -1; n_int_cyc = 0; n_int_win = 0; n_hold = 0; n_conv = 0; n_stb = 0;
    stb1_k = -1; stb2_k = -1; burst_left = 0; quiet_bad = 0; ch_bad = 0; first_win_conv = 0;
    prev_int = 1'b0;
    @(negedge clk_i);
    pix_count_i = PW'(p); settle_len_i = TW'(s); integ_len_i = TW'(i); conv_len_i = TW'(c);
    dwell_len_i = TW'(d); dwell_fast_len_i = TW'(df); fast_i = f[0];
    start_i = 1'b1;
    while (done_k < 0 && k < 20000) begin
      @(negedge clk_i);
      k++;
      start_i = 1'b0;
      if (disturb && k == 5) begin
        start_i = 1'b1;
        pix_count_i = 8'd9; settle_len_i = 8'd20; integ_len_i = 8'd7;
        conv_len_i = 8'd30; dwell_len_i = 8'd5; dwell_fast_len_i = 8'd4; fast_i = ~fast_i;
      end
      if (integ_o) n_int_cyc++;
      if (integ_o && !prev_int) n_int_win++;
      prev_int = integ_o;
      if (hold_o) n_hold++;
      if (conv_start_o) begin
        n_conv++;
        if (k <= a) first_win_conv++;
      end
      if (burst_o) begin
        if (burst_ch_o == '0) burst_left = b;
        if (int'(burst_ch_o) != n_stb % N_CH) ch_bad++;
        if (stb1_k < 0) stb1_k = k;
        else if (stb2_k < 0) stb2_k = k;
        n_stb++;
      end
      if (burst_left > 0) begin
        if (integ_o || hold_o || conv_start_o) quiet_bad++;
        burst_left--;
      end
      if (done_o) done_k = k;
    end
    @(negedge clk_i);
    chk({tag, " R7 done one cycle"}, int'(done_o), 0);
    chk({tag, " R7 latency"}, done_k, t + 1);
    chk({tag, " R8 integ cycles"}, n_int_cyc, p * i);
    chk({tag, " R8 integ windows"}, n_int_win, p);
    chk({tag, " R8 holds"}, n_hold, p);
    chk({tag, " R8 conv starts"}, n_conv, p);
    chk({tag, " R4 strobes"}, n_stb, p * N_CH);
    chk({tag, " R4 dwell spacing"}, stb2_k - stb1_k, de);
    chk({tag, " R4 channel order"}, ch_bad, 0);
    chk({tag, " R5 quiet burst"}, quiet_bad, 0);
    chk({tag, " R2 no conv in first window"}, first_win_conv, 0);
    // R3/R6: first strobe lands after first window A and conversion window max(A,C) (or C alone if P==1)
    chk({tag, " R3 R6 first burst start"}, stb1_k, a + ((p == 1) ? c : m) + 1);
  endtask

  initial begin
    #(1_500_000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset integ", int'(integ_o), 0);
    chk("R1 reset burst", int'(burst_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 idle silent", int'(integ_o | hold_o | conv_start_o | burst_o), 0);

    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6],
                1'b0, $sformatf("vec%0d", v));

    // R9: start and input changes mid-frame must be ignored
    run_frame(3, 3, 2, 4, 2, 1, 0, 1'b1, "disturb R9");

    // R2: first integrate begins exactly after settle ticks
    begin
      int k_int;
      k_int = -1;
      @(negedge clk_i);
      pix_count_i = 8'd2; settle_len_i = 8'd6; integ_len_i = 8'd3; conv_len_i = 8'd4;
      dwell_len_i = 8'd1; fast_i = 1'b0; start_i = 1'b1;
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk_i);
        start_i = 1'b0;
        if (integ_o && k_int < 0) k_int = k;
      end
      chk("R2 integ starts after settle", k_int, 7);
      // R1: asynchronous reset mid-frame clears every strobe
      rst_ni = 1'b0;
      #2;
      chk("R1 mid-frame reset strobes", int'(integ_o | hold_o | conv_start_o | burst_o | done_o), 0);
      @(negedge clk_i);
      rst_ni = 1'b1;
      repeat (5) @(negedge clk_i);
      chk("R1 idle after reset", int'(integ_o | hold_o | conv_start_o | burst_o | done_o), 0);
    end

    finish_run();
  end
endmodule